// File: doc/BRIEF.md
# Region Memory Attribute Checker

This block guards every instruction fetch, data load and data store that a processor core issues against a small attribute table. The 32-bit address space is cut into eight equal regions of 512 MiB. The top three address bits select the region. Translation is the identity, so the address that leaves the block is the address that came in. Each region holds a 4-bit attribute code that software can rewrite through a single write port. The core drives that port from its special-register write path.

The fetch side and the data side have their own checker, and both read the shared table in the same cycle. Each checker turns the region's code into a yes/no answer using a permission mask for its access kind: fetch, load or store. Every answered request reports either an allowed bypass access or a fault. A fault carries a cause code naming the access kind and returns the offending address. After reset every region holds code 2, an uncached mode in which execution is allowed.

Top module: `region_attr_guard`

## Requirements
- R1: The region of an access is address bits [31:29]. The check uses the code stored for exactly that region and for no other.
- R2: The response address equals the request address on all 32 bits. The three region bits are never altered, because the mapping is identity with a fixed page number per region.
- R3: After a synchronous active-low reset, all eight codes are 2. Fetch, load and store are therefore allowed in every region. While reset is held, both response valid outputs are low.
- R4: A fetch is allowed when the code is 1, 2, 3 or 4. For any other code it faults with cause 2'b01.
- R5: A load is allowed when the code is 0, 1, 2, 4 or 14. For any other code it faults with cause 2'b10.
- R6: A store is allowed for the same codes as a load (0, 1, 2, 4, 14). For any other code it faults with cause 2'b11.
- R7: Code 15 denies every access kind: fetch, load and store all fault.
- R8: Code 0 allows loads and stores but makes a fetch fault.
- R9: A code write takes effect at the clock edge that samples the write strobe. A check sampled at that same edge uses the previous code; the next check sees the new one.
- R10: A response appears exactly one cycle after its request, with valid high. With no request, valid is low the next cycle. An allowed response carries cause 2'b00.
- R11: The fetch side and the data side answer in the same cycle and independently, including when both address the same region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| attr_wr_en | input | 1 | Write strobe for one region's attribute code |
| attr_wr_region | input | 3 | Region whose code is written |
| attr_wr_code | input | 4 | New attribute code |
| ifetch_req | input | 1 | Fetch check request |
| ifetch_addr | input | 32 | Fetch address |
| data_req | input | 1 | Data check request |
| data_is_store | input | 1 | 1 = store, 0 = load |
| data_addr | input | 32 | Data address |
| ifetch_rsp_valid | output | 1 | Fetch response present |
| ifetch_rsp_allow | output | 1 | Fetch allowed as bypass access |
| ifetch_rsp_cause | output | 2 | 00 none, 01 fetch fault |
| ifetch_rsp_addr | output | 32 | Physical address, or faulting address |
| data_rsp_valid | output | 1 | Data response present |
| data_rsp_allow | output | 1 | Load/store allowed as bypass access |
| data_rsp_cause | output | 2 | 00 none, 10 load fault, 11 store fault |
| data_rsp_addr | output | 32 | Physical address, or faulting address |

## Verification
Each response is registered once. It is due in the cycle after the request's sampling edge. A code write changes what checks see from the edge that samples it, so only a request sampled at a later edge observes the new code. The bench drives inputs on the falling edge and samples outputs on the next falling edge, one rising edge later. It keeps its own copy of the table and updates that copy only after it has computed the expected results for the cycle in which the write is sampled. That way a same-cycle check is compared against the old code. The sweep covers every code in every region, for all three access kinds.

// File: rtl/rgn_attr_pkg.sv
// Shared types and default permission masks for the region attribute checker.
// Assumes a 4-bit attribute code; each mask bit k says whether code k allows
// the access kind as a bypass access.
package rgn_attr_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_FETCH = 2'b01,
        CAUSE_LOAD  = 2'b10,
        CAUSE_STORE = 2'b11
    } rgn_cause_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2
    } rgn_kind_e;

    // codes 1..4 execute
    localparam logic [15:0] DEF_FETCH_MASK = 16'h001E;
    // codes 0,1,2,4,14 read
    localparam logic [15:0] DEF_LOAD_MASK  = 16'h4017;
    // codes 0,1,2,4,14 write
    localparam logic [15:0] DEF_STORE_MASK = 16'h4017;

endpackage

// File: rtl/rgn_attr_table.sv
// Attribute table: one writable code per region, with a parameterised number
// of combinational read ports. Assumes a single write port; a write lands at
// the sampling edge, so a read in the same cycle returns the old code.
module rgn_attr_table #(
    parameter int NUM_REGIONS = 8,
    parameter int CODE_W      = 4,
    parameter int RESET_CODE  = 2,
    parameter int RD_PORTS    = 2,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [CODE_W-1:0]                 wr_code,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx,
    output logic [RD_PORTS-1:0][CODE_W-1:0]   rd_code
);

    localparam logic [CODE_W-1:0] RST_C = CODE_W'(RESET_CODE);

    logic [NUM_REGIONS-1:0][CODE_W-1:0] codes;

    // Holds the codes: reset to the default, then overwrite one region per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes <= {NUM_REGIONS{RST_C}};
        end else if (wr_en) begin
            codes[wr_idx] <= wr_code;
        end
    end

    // One lookup mux per read port.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb rd_code[p] = codes[rd_idx[p]];
    end

    // R3: leaving reset, every region holds the reset code
    a_r3_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> codes == {NUM_REGIONS{RST_C}});

    // R9: a write is visible from the following cycle
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> codes[$past(wr_idx)] == $past(wr_code));

    // R9: without a write nothing changes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$past(!rst_n)) |=> $stable(codes));

endmodule

// File: rtl/rgn_perm_decode.sv
// Permission decode: turns an attribute code and access kind into an allow
// bit by indexing the mask of that kind. Purely combinational.
module rgn_perm_decode
    import rgn_attr_pkg::*;
#(
    parameter int CODE_W                  = 4,
    localparam int NCODES                 = 1 << CODE_W,
    parameter logic [NCODES-1:0] FETCH_MASK = DEF_FETCH_MASK,
    parameter logic [NCODES-1:0] LOAD_MASK  = DEF_LOAD_MASK,
    parameter logic [NCODES-1:0] STORE_MASK = DEF_STORE_MASK
) (
    input  rgn_kind_e          kind,
    input  logic [CODE_W-1:0]  code,
    output logic               allow
);

    // Selects the mask of the access kind and picks the code's bit.
    always_comb begin
        case (kind)
            KIND_FETCH: allow = FETCH_MASK[code];
            KIND_LOAD:  allow = LOAD_MASK[code];
            KIND_STORE: allow = STORE_MASK[code];
            default:    allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/rgn_check_port.sv
// One checking side (fetch or data). Extracts the region index, receives the
// region's code from the table, decodes permission and registers the answer
// one cycle after the request. Assumes identity translation.
module rgn_check_port
    import rgn_attr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CODE_W    = 4,
    parameter int IDX_W     = 3,
    parameter bit IS_FETCH  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               is_store,
    input  logic [ADDR_W-1:0]  addr,
    output logic [IDX_W-1:0]   region,
    input  logic [CODE_W-1:0]  code,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output rgn_cause_e         rsp_cause,
    output logic [ADDR_W-1:0]  rsp_addr
);

    rgn_kind_e  kind;
    rgn_cause_e fault_cause;
    logic       allow;

    // Region index from the top address bits.
    always_comb region = addr[ADDR_W-1 -: IDX_W];

    // Access kind and the cause reported if it faults.
    always_comb begin
        if (IS_FETCH) begin
            kind        = KIND_FETCH;
            fault_cause = CAUSE_FETCH;
        end else if (is_store) begin
            kind        = KIND_STORE;
            fault_cause = CAUSE_STORE;
        end else begin
            kind        = KIND_LOAD;
            fault_cause = CAUSE_LOAD;
        end
    end

    rgn_perm_decode #(.CODE_W(CODE_W)) u_dec (
        .kind  (kind),
        .code  (code),
        .allow (allow)
    );

    // Response register: valid, decision, cause and identity-mapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req;
            rsp_allow <= req && allow;
            rsp_cause <= (req && !allow) ? fault_cause : CAUSE_NONE;
            rsp_addr  <= req ? addr : '0;
        end
    end

    // R10: a response follows every request by one cycle, and only then
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    // R2: response address is the request address
    a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_addr == $past(addr));

    // R10: allowed responses carry no cause, faults carry one
    a_r10_cause_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> rsp_cause == CAUSE_NONE);
    a_r10_cause_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> rsp_cause != CAUSE_NONE);

    // R7: code 15 never allows anything
    a_r7_code15_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req && code == '1) |=> !rsp_allow);

    // R4: the fetch side only ever reports the fetch cause
    if (IS_FETCH) begin : g_fetch_chk
        a_r4_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && !rsp_allow) |-> rsp_cause == CAUSE_FETCH);
    end else begin : g_data_chk
        a_r6_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (req && is_store) |=> (rsp_allow || rsp_cause == CAUSE_STORE));
    end

endmodule

// File: rtl/region_attr_guard.sv
// Top: shared attribute table with one read port per side, a fetch checker
// and a data checker. Both sides answer in the same cycle, independently.
module region_attr_guard #(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 8,
    parameter int CODE_W      = 4,
    parameter int RESET_CODE  = 2,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               attr_wr_en,
    input  logic [IDX_W-1:0]   attr_wr_region,
    input  logic [CODE_W-1:0]  attr_wr_code,
    input  logic               ifetch_req,
    input  logic [ADDR_W-1:0]  ifetch_addr,
    input  logic               data_req,
    input  logic               data_is_store,
    input  logic [ADDR_W-1:0]  data_addr,
    output logic               ifetch_rsp_valid,
    output logic               ifetch_rsp_allow,
    output logic [1:0]         ifetch_rsp_cause,
    output logic [ADDR_W-1:0]  ifetch_rsp_addr,
    output logic               data_rsp_valid,
    output logic               data_rsp_allow,
    output logic [1:0]         data_rsp_cause,
    output logic [ADDR_W-1:0]  data_rsp_addr
);
    import rgn_attr_pkg::*;

    localparam int SIDES = 2;

    logic [SIDES-1:0][IDX_W-1:0]  rd_idx;
    logic [SIDES-1:0][CODE_W-1:0] rd_code;
    rgn_cause_e                   if_cause, dt_cause;

    rgn_attr_table #(
        .NUM_REGIONS (NUM_REGIONS),
        .CODE_W      (CODE_W),
        .RESET_CODE  (RESET_CODE),
        .RD_PORTS    (SIDES)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (attr_wr_en),
        .wr_idx  (attr_wr_region),
        .wr_code (attr_wr_code),
        .rd_idx  (rd_idx),
        .rd_code (rd_code)
    );

    rgn_check_port #(
        .ADDR_W (ADDR_W), .CODE_W (CODE_W), .IDX_W (IDX_W), .IS_FETCH (1'b1)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ifetch_req),
        .is_store  (1'b0),
        .addr      (ifetch_addr),
        .region    (rd_idx[0]),
        .code      (rd_code[0]),
        .rsp_valid (ifetch_rsp_valid),
        .rsp_allow (ifetch_rsp_allow),
        .rsp_cause (if_cause),
        .rsp_addr  (ifetch_rsp_addr)
    );

    rgn_check_port #(
        .ADDR_W (ADDR_W), .CODE_W (CODE_W), .IDX_W (IDX_W), .IS_FETCH (1'b0)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (data_req),
        .is_store  (data_is_store),
        .addr      (data_addr),
        .region    (rd_idx[1]),
        .code      (rd_code[1]),
        .rsp_valid (data_rsp_valid),
        .rsp_allow (data_rsp_allow),
        .rsp_cause (dt_cause),
        .rsp_addr  (data_rsp_addr)
    );

    // Cause enums out to plain port vectors.
    always_comb begin
        ifetch_rsp_cause = if_cause;
        data_rsp_cause   = dt_cause;
    end

    // R3: nothing is answered in the cycle after reset was held
    a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!ifetch_rsp_valid && !data_rsp_valid));

endmodule

// File: tb/region_attr_guard_test.sv
module region_attr_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        attr_wr_en = 1'b0;
    logic [2:0]  attr_wr_region = '0;
    logic [3:0]  attr_wr_code = '0;
    logic        ifetch_req = 1'b0;
    logic [31:0] ifetch_addr = '0;
    logic        data_req = 1'b0;
    logic        data_is_store = 1'b0;
    logic [31:0] data_addr = '0;
    logic        ifetch_rsp_valid, ifetch_rsp_allow;
    logic [1:0]  ifetch_rsp_cause;
    logic [31:0] ifetch_rsp_addr;
    logic        data_rsp_valid, data_rsp_allow;
    logic [1:0]  data_rsp_cause;
    logic [31:0] data_rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [3:0] model [8];

    always #2.5 clk = ~clk;

    region_attr_guard uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit fetch_ok(input logic [3:0] c);
        return (c >= 4'd1) && (c <= 4'd4);
    endfunction

    function automatic bit data_ok(input logic [3:0] c);
        return (c <= 4'd2) || (c == 4'd4) || (c == 4'd14);
    endfunction

    function automatic logic [31:0] mk_addr(input int r, input int salt);
        logic [31:0] off;
        off = 32'(salt) * 32'h0123_4567 + 32'(r) * 32'h89AB;
        return {3'(r), off[28:0]};
    endfunction

    // One cycle: drive on falling edge, check after the next rising edge.
    task automatic cycle(input bit wr, input int wr_r, input int wr_c,
                         input bit fr, input logic [31:0] fa,
                         input bit dr, input bit ds, input logic [31:0] da,
                         input string tag);
        logic [3:0] fc, dc;
        bit fok, dok;
        fc = model[fa[31:29]];
        dc = model[da[31:29]];
        fok = fetch_ok(fc);
        dok = data_ok(dc);
        attr_wr_en = wr; attr_wr_region = 3'(wr_r); attr_wr_code = 4'(wr_c);
        ifetch_req = fr; ifetch_addr = fa;
        data_req = dr; data_is_store = ds; data_addr = da;
        @(posedge clk);
        if (wr) model[wr_r] = 4'(wr_c);   // R9: expectations used the old code
        @(negedge clk);
        attr_wr_en = 1'b0; ifetch_req = 1'b0; data_req = 1'b0;
        check({tag, " R10 fetch valid"}, 32'(ifetch_rsp_valid), 32'(fr));
        check({tag, " R10 data valid"}, 32'(data_rsp_valid), 32'(dr));
        if (fr) begin
            check({tag, " R4 fetch allow"}, 32'(ifetch_rsp_allow), 32'(fok));
            check({tag, " R4 fetch cause"}, 32'(ifetch_rsp_cause), fok ? 32'd0 : 32'd1);
            check({tag, " R2 fetch addr"}, ifetch_rsp_addr, fa);
        end
        if (dr) begin
            check({tag, ds ? " R6 store allow" : " R5 load allow"},
                  32'(data_rsp_allow), 32'(dok));
            check({tag, ds ? " R6 store cause" : " R5 load cause"},
                  32'(data_rsp_cause), dok ? 32'd0 : (ds ? 32'd3 : 32'd2));
            check({tag, " R2 data addr"}, data_rsp_addr, da);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 fetch valid low in reset", 32'(ifetch_rsp_valid), 32'd0);
        check("R3 data valid low in reset", 32'(data_rsp_valid), 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) model[k] = 4'd2;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        do_reset();
        // R3: every region allows all three kinds after reset
        for (int r = 0; r < 8; r++) begin
            cycle(0, 0, 0, 1, mk_addr(r, 1), 1, 0, mk_addr(r, 2), "R3 reset load");
            cycle(0, 0, 0, 0, '0, 1, 1, mk_addr(r, 3), "R3 reset store");
        end
        // R1 R4 R5 R6 R7 R8 R9 R11: every code in every region
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 16; c++) begin
                cycle(1, r, c, 1, mk_addr(r, c), 1, 0, mk_addr(r, c + 5), "R9 same-cycle old");
                cycle(0, 0, 0, 1, mk_addr(r, c + 9), 1, 1, mk_addr(r, c + 11), "R11 both sides");
                cycle(0, 0, 0, 0, '0, 1, 0, mk_addr(r, c + 13), "R8 R7 load new");
            end
        end
        // R1: neighbouring regions keep separate codes
        cycle(1, 3, 1, 0, '0, 0, 0, '0, "R10 idle");
        cycle(1, 4, 0, 1, mk_addr(3, 7), 1, 0, mk_addr(4, 8), "R1 region 3 vs 4");
        cycle(0, 0, 0, 1, mk_addr(4, 9), 1, 1, mk_addr(3, 2), "R1 region 4 vs 3");
        cycle(0, 0, 0, 1, 32'hFFFF_FFFF, 1, 1, 32'h0000_0000, "R2 edge addresses");
        // R3: reset again restores the default code
        do_reset();
        cycle(0, 0, 0, 1, mk_addr(7, 3), 1, 1, mk_addr(0, 4), "R3 second reset");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule